// File: doc/BRIEF.md
# Gate Driver Control and Protection Core

This block is the digital heart of a single-channel isolated gate driver for a power switch. It accepts a non-inverting and an inverting drive input plus an active-low shutdown/reset input, all asynchronous. Each of the three passes through a two-flop synchronizer and a glitch filter. It also takes synchronous status bits: a desaturation comparator, a gate-low comparator, undervoltage flags for the input and output sides, and a link error flag. From these it produces the gate-on command, a Miller clamp enable, an active-low fault flag and a ready flag.

The control path is a four-state machine. IDLE holds the gate off. BLANK drives the gate on while the desaturation bit is ignored for a parameter number of cycles. CONDUCT drives the gate on with desaturation monitored. TRIP holds the gate off with the fault flag low. The transitions are as follows. IDLE goes to BLANK when the drive request is true. BLANK goes to IDLE when the request drops, and to CONDUCT when the blanking count expires. CONDUCT goes to TRIP when desaturation is seen, and to IDLE when the request drops. TRIP goes to IDLE only on a qualified rising edge of the shutdown input, which means the rising edge must follow a low time of at least a parameter number of cycles.

The drive request is true when four conditions hold together: the filtered non-inverting input is high, the filtered inverting input is low, the filtered shutdown input is high, and no supply or link error is present.

Top module: `gate_drv_ctrl`

## Requirements
- R1: The drive request is true only for non-inverting input 1 with inverting input 0. The other three input combinations keep `gate_on_o` at 0.
- R2: A level on any of the three asynchronous inputs must hold for at least FILT_CYC clock cycles (default 5) to take effect. Shorter pulses leave `gate_on_o` unchanged.
- R3: While the filtered shutdown input is low, `gate_on_o` is 0.
- R4: In CONDUCT, an asserted desaturation bit moves the block to TRIP. The gate command then goes to 0 and `fault_no` goes to 0 on the next clock. With desaturation held high from turn-on, the gate stays on for exactly BLANK_CYC+1 cycles.
- R5: During BLANK, the desaturation bit is ignored. The blanking count restarts at every turn-on.
- R6: TRIP is left, and `fault_no` returns to 1, only at a rising edge of the filtered shutdown input that follows at least RST_LOW_CYC cycles (default 100) of low. A shorter low pulse leaves the fault in place.
- R7: Any of input-side undervoltage, output-side undervoltage or link error forces `gate_on_o` to 0 within two cycles. The gate returns on once the error clears and the request is still true.
- R8: `clamp_en_o` rises one cycle after `gate_low_i` is seen while the gate command is off. It then stays high while the gate is off, even if `gate_low_i` falls. It is 0 whenever `gate_on_o` is 1.
- R9: `ready_o` equals 1 only when none of `uv_in_i`, `uv_out_i` and `link_err_i` is set. It follows them in the same cycle, without reset.
- R10: A change on a drive input reaches `gate_on_o` exactly FILT_CYC+3 rising edges after it is applied. The cycles are made up of two synchronizer stages, FILT_CYC filter cycles and one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous chip reset, active low |
| drv_pos_i | input | 1 | Non-inverting drive input (asynchronous) |
| drv_neg_i | input | 1 | Inverting drive input (asynchronous) |
| shut_ni | input | 1 | Shutdown / fault-clear input, active low (asynchronous) |
| desat_i | input | 1 | Desaturation comparator result |
| gate_low_i | input | 1 | Gate voltage below clamp threshold |
| uv_in_i | input | 1 | Input-side undervoltage |
| uv_out_i | input | 1 | Output-side undervoltage |
| link_err_i | input | 1 | Internal transmission error |
| gate_on_o | output | 1 | Gate-on command |
| clamp_en_o | output | 1 | Miller clamp enable |
| fault_no | output | 1 | Desaturation fault flag, active low |
| ready_o | output | 1 | Supplies and link healthy |

## Verification
The assertions check several properties on every cycle. The filtered levels may change only at the end of a full stability count. Shutdown and errors must force the gate off in the following cycle. A desaturation hit in CONDUCT must drop the fault flag. The fault flag may rise only on a qualified clear. The clamp and the gate command must never both be high. The bench scenarios are needed for the timing-dependent behaviour that no single-cycle property shows. This covers the exact pulse width at which the filters pass or reject, the exact turn-on latency, the length of the gate-on window when desaturation is held, and the low-time threshold of the fault clear. The bench sweeps each of these across its boundary.

// File: rtl/gdc_pkg.sv
package gdc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_BLANK   = 2'd1,
        ST_CONDUCT = 2'd2,
        ST_TRIP    = 2'd3
    } gdc_state_e;
endpackage

// File: rtl/gdc_in_filter.sv
module gdc_in_filter #(
    parameter int   FILT_CYC = 5,
    parameter logic RST_VAL  = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d_i,
    output logic q_o
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic          s1_q, s2_q, filt_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            s1_q <= RST_VAL;
            s2_q <= RST_VAL;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
        end
    end

    // A new level is adopted only after FILT_CYC consecutive disagreeing samples.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            filt_q <= RST_VAL;
            cnt_q  <= '0;
        end else if (s2_q == filt_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(FILT_CYC - 1)) begin
            filt_q <= s2_q;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign q_o = filt_q;

    assert_filter_hold_R2: assert property (@(posedge clk) disable iff (!arst_n)
        !$stable(filt_q) |-> ($past(cnt_q) == CW'(FILT_CYC - 1)));
endmodule

// File: rtl/gdc_rst_qual.sv
module gdc_rst_qual #(
    parameter int RST_LOW_CYC = 100
) (
    input  logic clk,
    input  logic arst_n,
    input  logic en_f_i,
    output logic clr_o
);
    localparam int CW = $clog2(RST_LOW_CYC + 1);

    logic          prev_q;
    logic [CW-1:0] low_cnt_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            prev_q    <= 1'b0;
            low_cnt_q <= '0;
        end else begin
            prev_q <= en_f_i;
            if (en_f_i)
                low_cnt_q <= '0;
            else if (low_cnt_q != CW'(RST_LOW_CYC))
                low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    // Qualified rising edge: enough low cycles counted before it.
    assign clr_o = en_f_i && !prev_q && (low_cnt_q == CW'(RST_LOW_CYC));
endmodule

// File: rtl/gdc_seq.sv
module gdc_seq
    import gdc_pkg::*;
#(
    parameter int BLANK_CYC = 16
) (
    input  logic clk,
    input  logic arst_n,
    input  logic pos_f_i,
    input  logic neg_f_i,
    input  logic en_f_i,
    input  logic desat_i,
    input  logic gate_low_i,
    input  logic err_i,
    input  logic clr_i,
    output logic gate_on_o,
    output logic clamp_en_o,
    output logic fault_no
);
    localparam int BW = $clog2(BLANK_CYC + 1);

    gdc_state_e    state_q, state_d;
    logic [BW-1:0] blank_q;
    logic          req, on_d;

    assign req  = pos_f_i && !neg_f_i && en_f_i && !err_i;
    assign on_d = (state_d == ST_BLANK) || (state_d == ST_CONDUCT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req) state_d = ST_BLANK;
            ST_BLANK:   if (!req) state_d = ST_IDLE;
                        else if (blank_q == BW'(BLANK_CYC - 1)) state_d = ST_CONDUCT;
            ST_CONDUCT: if (desat_i) state_d = ST_TRIP;
                        else if (!req) state_d = ST_IDLE;
            ST_TRIP:    if (clr_i) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register and blanking counter (restarts at each turn-on).
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q <= ST_IDLE;
            blank_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_BLANK && state_q == ST_BLANK)
                blank_q <= blank_q + 1'b1;
            else
                blank_q <= '0;
        end
    end

    // Registered outputs.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            gate_on_o  <= 1'b0;
            clamp_en_o <= 1'b0;
            fault_no   <= 1'b1;
        end else begin
            gate_on_o  <= on_d;
            fault_no   <= (state_d != ST_TRIP);
            clamp_en_o <= !on_d && (clamp_en_o || gate_low_i);
        end
    end

    assert_shutdown_off_R3: assert property (@(posedge clk) disable iff (!arst_n)
        !en_f_i |=> !gate_on_o);
    assert_error_off_R7: assert property (@(posedge clk) disable iff (!arst_n)
        err_i |=> !gate_on_o);
    assert_desat_trip_R4: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q == ST_CONDUCT && desat_i) |=> (!fault_no && !gate_on_o));
    assert_fault_clear_R6: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(fault_no) |-> $past(clr_i));
    assert_clamp_exclusive_R8: assert property (@(posedge clk) disable iff (!arst_n)
        !(gate_on_o && clamp_en_o));
endmodule

// File: rtl/gate_drv_ctrl.sv
module gate_drv_ctrl #(
    parameter int FILT_CYC    = 5,
    parameter int RST_LOW_CYC = 100,
    parameter int BLANK_CYC   = 16
) (
    input  logic clk,
    input  logic arst_n,
    input  logic drv_pos_i,
    input  logic drv_neg_i,
    input  logic shut_ni,
    input  logic desat_i,
    input  logic gate_low_i,
    input  logic uv_in_i,
    input  logic uv_out_i,
    input  logic link_err_i,
    output logic gate_on_o,
    output logic clamp_en_o,
    output logic fault_no,
    output logic ready_o
);
    localparam int          NIN      = 3;
    // Safe idle levels: non-inverting low, inverting high, shutdown asserted.
    localparam logic [NIN-1:0] FILT_RST = 3'b010;

    logic [NIN-1:0] raw, filt;
    logic           err, clr;

    assign raw = {shut_ni, drv_neg_i, drv_pos_i};

    for (genvar g = 0; g < NIN; g++) begin : g_filt
        gdc_in_filter #(
            .FILT_CYC (FILT_CYC),
            .RST_VAL  (FILT_RST[g])
        ) u_filt (
            .clk    (clk),
            .arst_n (arst_n),
            .d_i    (raw[g]),
            .q_o    (filt[g])
        );
    end

    assign err     = uv_in_i || uv_out_i || link_err_i;
    assign ready_o = !err;

    gdc_rst_qual #(.RST_LOW_CYC(RST_LOW_CYC)) u_rst_qual (
        .clk    (clk),
        .arst_n (arst_n),
        .en_f_i (filt[2]),
        .clr_o  (clr)
    );

    gdc_seq #(.BLANK_CYC(BLANK_CYC)) u_seq (
        .clk        (clk),
        .arst_n     (arst_n),
        .pos_f_i    (filt[0]),
        .neg_f_i    (filt[1]),
        .en_f_i     (filt[2]),
        .desat_i    (desat_i),
        .gate_low_i (gate_low_i),
        .err_i      (err),
        .clr_i      (clr),
        .gate_on_o  (gate_on_o),
        .clamp_en_o (clamp_en_o),
        .fault_no   (fault_no)
    );

    assert_not_ready_off_R9: assert property (@(posedge clk) disable iff (!arst_n)
        !ready_o |=> !gate_on_o);
endmodule

// File: tb/gate_drv_ctrl_tb_top.sv
module gate_drv_ctrl_tb_top;
    localparam int FILT  = 5;
    localparam int RLOW  = 100;
    localparam int BLANK = 16;
    localparam int LAT   = FILT + 3;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic drv_pos = 1'b0, drv_neg = 1'b0, shut_n = 1'b1;
    logic desat = 1'b0, gate_low = 1'b1;
    logic uv_in = 1'b0, uv_out = 1'b0, link_err = 1'b0;
    logic gate_on, clamp_en, fault_n, ready;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    gate_drv_ctrl #(.FILT_CYC(FILT), .RST_LOW_CYC(RLOW), .BLANK_CYC(BLANK)) dut_i (
        .clk(clk), .arst_n(arst_n), .drv_pos_i(drv_pos), .drv_neg_i(drv_neg),
        .shut_ni(shut_n), .desat_i(desat), .gate_low_i(gate_low), .uv_in_i(uv_in),
        .uv_out_i(uv_out), .link_err_i(link_err), .gate_on_o(gate_on),
        .clamp_en_o(clamp_en), .fault_no(fault_n), .ready_o(ready)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic make_fault();
        desat = 1'b1; drv_pos = 1'b1;
        tick(LAT + BLANK + 10);
        drv_pos = 1'b0; desat = 1'b0;
        tick(12);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        arst_n = 1'b1;
        tick(20);
        // Reset state
        chk("R3 reset gate", gate_on, 1'b0);
        chk("R6 reset fault", fault_n, 1'b1);
        chk("R8 reset clamp with gate low", clamp_en, 1'b1);

        // R9: exhaustive over the three error flags
        for (int k = 0; k < 8; k++) begin
            {uv_in, uv_out, link_err} = 3'(k);
            tick(1);
            chk("R9 ready", ready, (k == 0));
        end
        {uv_in, uv_out, link_err} = 3'b000;
        tick(2);

        // R1: all four input combinations
        for (int k = 0; k < 4; k++) begin
            drv_pos = k[0]; drv_neg = k[1];
            tick(20);
            chk("R1 polarity", gate_on, (k[0] && !k[1]));
        end
        drv_pos = 1'b0; drv_neg = 1'b0;
        tick(20);

        // R10: exact turn-on latency
        drv_pos = 1'b1;
        tick(LAT - 1);
        chk("R10 before latency", gate_on, 1'b0);
        tick(1);
        chk("R10 at latency", gate_on, 1'b1);
        drv_pos = 1'b0;
        tick(20);

        // R2: pulse width sweep on the non-inverting input
        for (int w = 1; w <= FILT + 2; w++) begin
            logic seen;
            seen = 1'b0;
            drv_pos = 1'b1;
            for (int t = 0; t < w; t++) begin tick(1); seen |= gate_on; end
            drv_pos = 1'b0;
            for (int t = 0; t < 25; t++) begin tick(1); seen |= gate_on; end
            chk("R2 pos pulse", seen, (w >= FILT));
        end

        // R2/R3: low pulse sweep on shutdown while the gate is on
        drv_pos = 1'b1;
        tick(20);
        for (int w = 1; w <= FILT + 2; w++) begin
            logic dropped;
            dropped = 1'b0;
            shut_n = 1'b0;
            for (int t = 0; t < w; t++) begin tick(1); dropped |= !gate_on; end
            shut_n = 1'b1;
            for (int t = 0; t < 25; t++) begin tick(1); dropped |= !gate_on; end
            chk("R3 shutdown pulse", dropped, (w >= FILT));
            chk("R3 gate restored", gate_on, 1'b1);
        end
        shut_n = 1'b0;
        tick(30);
        chk("R3 held shutdown", gate_on, 1'b0);
        shut_n = 1'b1;
        tick(30);

        // R7: each error forces the gate off, release restores it
        for (int k = 0; k < 3; k++) begin
            {uv_in, uv_out, link_err} = 3'(1 << k);
            tick(2);
            chk("R7 error off", gate_on, 1'b0);
            {uv_in, uv_out, link_err} = 3'b000;
            tick(3);
            chk("R7 error release", gate_on, 1'b1);
        end

        // R8: clamp behaviour
        gate_low = 1'b0;
        chk("R8 clamp off while on", clamp_en, 1'b0);
        drv_pos = 1'b0;
        tick(LAT + 3);
        chk("R8 clamp waits for gate low", clamp_en, 1'b0);
        gate_low = 1'b1;
        tick(2);
        chk("R8 clamp set", clamp_en, 1'b1);
        gate_low = 1'b0;
        tick(3);
        chk("R8 clamp holds", clamp_en, 1'b1);
        drv_pos = 1'b1;
        tick(LAT + 1);
        chk("R8 clamp released on turn-on", clamp_en, 1'b0);
        drv_pos = 1'b0;
        tick(20);

        // R5: desaturation during blanking only, twice to cover the restart
        for (int r = 0; r < 2; r++) begin
            desat = 1'b1; drv_pos = 1'b1;
            tick(LAT + BLANK - 4);
            desat = 1'b0;
            tick(30);
            chk("R5 no trip in blanking", fault_n, 1'b1);
            chk("R5 gate still on", gate_on, 1'b1);
            drv_pos = 1'b0;
            tick(20);
        end

        // R4: desaturation held from turn-on
        begin
            int cnt;
            cnt = 0;
            desat = 1'b1; drv_pos = 1'b1;
            for (int t = 0; t < LAT + BLANK + 30; t++) begin tick(1); cnt += gate_on; end
            checks++;
            if (cnt != BLANK + 1) begin
                errors++;
                $display("FAIL R4 on-window actual=%0d expected=%0d", cnt, BLANK + 1);
            end
            chk("R4 fault low", fault_n, 1'b0);
            chk("R4 gate off", gate_on, 1'b0);
            desat = 1'b0;
            uv_in = 1'b1; tick(3); uv_in = 1'b0; tick(3);
            chk("R7 error does not clear fault", fault_n, 1'b0);
            drv_pos = 1'b0;
            tick(10);
        end

        // R6: fault-clear low-time sweep
        begin
            int ws [6] = '{3, 60, RLOW - 1, RLOW, RLOW + 1, RLOW + 40};
            foreach (ws[i]) begin
                make_fault();
                chk("R6 fault set", fault_n, 1'b0);
                shut_n = 1'b0;
                tick(ws[i]);
                shut_n = 1'b1;
                tick(20);
                chk("R6 clear threshold", fault_n, (ws[i] >= RLOW));
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule